// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external 16-bit static memory that has no clock. The host issues a request, with a write flag, an address, a 16-bit write word and a two-bit byte mask, in any cycle where the controller reports ready. The controller then plays out the memory's control sequence using counted clock cycles. Reads hold chip select and output enable low for a programmable access window and then capture the word. Writes assert chip select and drive the data a set number of cycles before the write strobe, hold the strobe for a minimum width, and keep the data on the bus for a recovery period after the strobe ends.

The mask is applied per lane on both reads and writes. Bit 0 drives the active-low lower-lane select and bit 1 drives the active-low upper-lane select. The memory address and the lane selects are frozen while chip select is low. After every read, the output enable is released and a turnaround interval follows, so the controller never drives the shared data bus against the memory's output drivers. Every timing interval is a parameter in clock cycles, so one netlist can serve several clock rates and memory speed grades.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are all 1, and mem_dq_oe is 0.
- R2: A read returns, on rsp_rdata, the word last written at that address, with rsp_valid high for exactly one cycle. req_ready stays low for RD_CYC+1+TA_CYC cycles after the accepting edge.
- R3: Read data is sampled only after chip select and output enable have both been low for RD_CYC+1 consecutive cycles.
- R4: On a read, mask bit 0 low forces rsp_rdata[7:0] to zero and mask bit 1 low forces rsp_rdata[15:8] to zero. Lane selects follow the mask: bit 0 drives mem_lb_n and bit 1 drives mem_ub_n, both active low.
- R5: For a write, chip select is low and mem_dq_oe is high for SU_CYC cycles before mem_we_n falls. mem_we_n then stays low for exactly WP_CYC cycles, and data stays driven for RC_CYC cycles after it rises. req_ready is low for SU_CYC+WP_CYC+RC_CYC cycles.
- R6: A write updates only the lanes whose mask bit is 1. A mask of 00 leaves the memory unchanged.
- R7: mem_addr, mem_lb_n and mem_ub_n do not change while mem_cs_n stays low.
- R8: mem_dq_oe is never high while mem_oe_n is low, and mem_oe_n has been high for at least two cycles before mem_dq_oe rises.
- R9: A request presented while req_ready is low is ignored.
- R10: mem_we_n is low only while mem_cs_n is low and mem_oe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane mask, bit 0 lower lane, bit 1 upper lane |
| req_ready | output | 1 | High only when idle |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_rdata | output | 16 | Captured read word, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Bus drive enable for mem_dq_out |

## Verification
Two events can meet in one cycle. The first is the read-response strobe, which falls inside the turnaround interval. The second is a fresh host request that arrives while the controller is still busy. The bench raises a competing write request on the first busy cycle of a read and holds it until ready returns. It then judges the outcome from three things: the busy length matches the read alone, exactly one response strobe arrives, and a later read shows the targeted word unchanged. A memory model returns a marker pattern until the access window has fully elapsed, so a capture taken even one cycle early shows up as a data mismatch.

// File: rtl/async_sram_ctl.sv
module async_sram_ctl #(
  parameter int ADDR_W = 16,
  parameter int RD_CYC = 3,
  parameter int TA_CYC = 1,
  parameter int SU_CYC = 1,
  parameter int WP_CYC = 2,
  parameter int RC_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_out,
  input  logic [15:0]       mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int MAXC_A = (RD_CYC > TA_CYC) ? RD_CYC : TA_CYC;
  localparam int MAXC_B = (SU_CYC > WP_CYC) ? SU_CYC : WP_CYC;
  localparam int MAXC_C = (MAXC_A > MAXC_B) ? MAXC_A : MAXC_B;
  localparam int MAXC   = (MAXC_C > RC_CYC) ? MAXC_C : RC_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    IDLE, READ_WAIT, READ_CAPTURE, WRITE_SETUP, WRITE_PULSE, WRITE_RECOVER, TURNAROUND
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [ADDR_W-1:0] a_q;
  logic [15:0]      d_q;
  logic [1:0]       be_q;
  logic             rd_ph, wr_ph, last;

  assign last  = (cnt == '0);
  assign rd_ph = (st == READ_WAIT) || (st == READ_CAPTURE);
  assign wr_ph = (st == WRITE_SETUP) || (st == WRITE_PULSE) || (st == WRITE_RECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      a_q       <= '0;
      d_q       <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          a_q  <= req_addr;
          d_q  <= req_wdata;
          be_q <= req_be;
          if (req_write) begin
            st  <= WRITE_SETUP;
            cnt <= CW'(SU_CYC - 1);
          end else begin
            st  <= READ_WAIT;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        READ_WAIT: if (last) st <= READ_CAPTURE;
                   else cnt <= cnt - 1'b1;
        READ_CAPTURE: begin
          rsp_rdata <= {be_q[1] ? mem_dq_in[15:8] : 8'h00,
                        be_q[0] ? mem_dq_in[7:0]  : 8'h00};
          rsp_valid <= 1'b1;
          st        <= TURNAROUND;
          cnt       <= CW'(TA_CYC - 1);
        end
        TURNAROUND: if (last) st <= IDLE;
                    else cnt <= cnt - 1'b1;
        WRITE_SETUP: if (last) begin
          st  <= WRITE_PULSE;
          cnt <= CW'(WP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        WRITE_PULSE: if (last) begin
          st  <= WRITE_RECOVER;
          cnt <= CW'(RC_CYC - 1);
        end else cnt <= cnt - 1'b1;
        WRITE_RECOVER: if (last) st <= IDLE;
                       else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign req_ready  = (st == IDLE);
  assign mem_addr   = a_q;
  assign mem_cs_n   = !(rd_ph || wr_ph);
  assign mem_oe_n   = !rd_ph;
  assign mem_we_n   = (st != WRITE_PULSE);
  assign mem_lb_n   = !((rd_ph || wr_ph) && be_q[0]);
  assign mem_ub_n   = !((rd_ph || wr_ph) && be_q[1]);
  assign mem_dq_oe  = wr_ph;
  assign mem_dq_out = d_q;
endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int WP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              mem_dq_oe
);
  int we_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) we_run <= 0;
    else we_run <= mem_we_n ? 0 : we_run + 1;

  p_we_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));
  p_addr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WP_CYC));
  p_setup_before_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_dq_oe)));
  p_busy_when_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind async_sram_ctl async_sram_ctl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (.*);

// File: tb/async_sram_ctl_tb.sv
module async_sram_ctl_tb;
  localparam int AW = 4, RD = 5, TA = 2, SU = 1, WP = 3, RC = 1;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #2 clk = ~clk;

  async_sram_ctl #(.ADDR_W(AW), .RD_CYC(RD), .TA_CYC(TA), .SU_CYC(SU), .WP_CYC(WP), .RC_CYC(RC)) u_dut (.*);

  logic [15:0] mem [NW];
  logic [15:0] shadow [NW];
  int age = 0, we_cnt = 0, v7 = 0, v8 = 0, v10 = 0;
  logic pcs = 1; logic [AW-1:0] paddr = '0; logic plb = 1, pub = 1;
  int total = 0, bad = 0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) mem[mem_addr][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) mem[mem_addr][15:8] <= mem_dq_out[15:8];
    end
    age <= (!mem_cs_n && !mem_oe_n) ? age + 1 : 0;
    if (!mem_we_n) we_cnt <= we_cnt + 1;
    if (rst_n) begin
      if (!pcs && !mem_cs_n && (paddr != mem_addr || plb != mem_lb_n || pub != mem_ub_n)) v7 <= v7 + 1;
      if (mem_dq_oe && !mem_oe_n) v8 <= v8 + 1;
      if (!mem_we_n && (mem_cs_n || !mem_oe_n)) v10 <= v10 + 1;
    end
    pcs <= mem_cs_n; paddr <= mem_addr; plb <= mem_lb_n; pub <= mem_ub_n;
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && age >= RD) ?
    {mem_ub_n ? 8'hEE : mem[mem_addr][15:8], mem_lb_n ? 8'hEE : mem[mem_addr][7:0]} : 16'hEEEE;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input bit w, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be,
                    input bit spur, output logic [15:0] rd, output int busy, output int vc);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    we_cnt = 0;
    @(negedge clk);
    req_valid = 0;
    busy = 0; vc = 0; rd = 'x;
    while (!req_ready) begin
      if (spur && busy == 0) begin
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = 16'h7777; req_be = 2'b11;
      end
      if (rsp_valid) begin vc++; rd = rsp_rdata; end
      busy++;
      @(negedge clk);
      if (busy > 100) break;
    end
    req_valid = 0;
    if (rsp_valid) vc++;
  endtask

  function automatic logic [15:0] pat(input int a, input int k);
    return {4'(a), 4'(k), 4'(~a), 4'(k + 3)};
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] be);
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog actual=0 expected=1");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd; int busy, vc;
    for (int i = 0; i < NW; i++) begin mem[i] = 16'h0000; shadow[i] = 16'h0000; end
    #1;
    // R1 reset state
    chk(req_ready && !rsp_valid && mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
        "R1 reset", {req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 8'b10111110);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R5 full writes, every address
    for (int a = 0; a < NW; a++) begin
      op(1, a[AW-1:0], pat(a, 0), 2'b11, 0, rd, busy, vc);
      shadow[a] = pat(a, 0);
      chk(busy == SU + WP + RC, "R5 write busy", busy, SU + WP + RC);
      chk(we_cnt == WP, "R5 strobe width", we_cnt, WP);
    end
    // R2 R3 full reads
    for (int a = 0; a < NW; a++) begin
      op(0, a[AW-1:0], 16'h0, 2'b11, 0, rd, busy, vc);
      chk(rd == shadow[a], "R2 R3 read data", rd, shadow[a]);
      chk(busy == RD + 1 + TA, "R2 read busy", busy, RD + 1 + TA);
      chk(vc == 1, "R2 single strobe", vc, 1);
      chk(we_cnt == 0, "R10 no strobe on read", we_cnt, 0);
    end
    // R6 partial writes with every mask, then full readback
    for (int a = 0; a < NW; a++) begin
      logic [1:0] m = 2'(a);
      logic [15:0] d = pat(a, 1);
      op(1, a[AW-1:0], d, m, 0, rd, busy, vc);
      shadow[a] = {m[1] ? d[15:8] : shadow[a][15:8], m[0] ? d[7:0] : shadow[a][7:0]};
      chk(we_cnt == WP, "R6 strobe count", we_cnt, WP);
    end
    for (int a = 0; a < NW; a++) begin
      op(0, a[AW-1:0], 16'h0, 2'b11, 0, rd, busy, vc);
      chk(rd == shadow[a], "R6 lane write", rd, shadow[a]);
    end
    // R4 masked reads
    for (int a = 0; a < NW; a++) begin
      for (int m = 0; m < 4; m++) begin
        op(0, a[AW-1:0], 16'h0, 2'(m), 0, rd, busy, vc);
        chk(rd == lanes(shadow[a], 2'(m)), "R4 lane read", rd, lanes(shadow[a], 2'(m)));
      end
    end
    // R9 request during busy ignored
    for (int a = 0; a < 4; a++) begin
      op(0, a[AW-1:0], 16'h0, 2'b11, 1, rd, busy, vc);
      chk(busy == RD + 1 + TA && vc == 1, "R9 busy unchanged", busy, RD + 1 + TA);
      op(0, a[AW-1:0], 16'h0, 2'b11, 0, rd, busy, vc);
      chk(rd == shadow[a], "R9 word unchanged", rd, shadow[a]);
    end
    // R8 write immediately after read, then readback
    op(0, 3, 16'h0, 2'b11, 0, rd, busy, vc);
    op(1, 3, pat(3, 2), 2'b11, 0, rd, busy, vc);
    shadow[3] = pat(3, 2);
    op(0, 3, 16'h0, 2'b11, 0, rd, busy, vc);
    chk(rd == shadow[3], "R8 write after read", rd, shadow[3]);

    chk(v7 == 0, "R7 address stable", v7, 0);
    chk(v8 == 0, "R8 bus contention", v8, 0);
    chk(v10 == 0, "R10 strobe qualification", v10, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule